// File: doc/BRIEF.md
# Serial Control Bit Register Bank

This block holds the single-bit controls of a floppy interface card, written one bit at a time over a serial bit-addressed I/O bus. Each write carries a byte offset and one data bit. When the offset falls inside the bank's window, a four-bit field of the offset chooses which control bit is loaded.

The controls cover the following:
- card enable and the motor trigger;
- wait-state enable and head load;
- four drive selects and the side select;
- the density flag;
- two ROM page bits and a RAM page bit;
- the clock-chip enable.

Several drive selects may be set at the same time. The block therefore reduces them to one drive index, and the highest-numbered drive wins.

A read at the bank's first byte returns a status byte. It gathers the drive-absent flags and the configuration switches, and every bit is inverted before it is returned. The drives, the disk controller and the clock chip are outside the block.

Top module: `ctl_bit_bank`

## Requirements
- R1: A write takes effect on the rising clock edge only when `wr_en` is high and `(offset & 16'hFF00) == BASE`, with `BASE` defaulting to 16'h1100. The control bit number is `offset[4:1]`. Offset bit 0 and offset bits 7:5 do not affect which bit is written.
- R2: The control bit numbers load these outputs:
  - bit 0 loads `card_en`; bit 1 loads `motor_trig`; bit 2 loads `wait_en`; bit 3 loads `head_load`.
  - bits 4, 5 and 6 load `drv_sel[0]`, `drv_sel[1]` and `drv_sel[2]`; bit 8 loads `drv_sel[3]`.
  - bit 7 loads `side`; bit 10 loads `dens`.
  - bit 11 loads `rom_page[0]` and bit 15 loads `rom_page[1]`.
  - bit 13 loads `ram_page`; bit 14 loads `rtc_en`.
- R3: Writes to control bit numbers 9 and 12 change no output.
- R4: When any `drv_sel` bit is set, `drv_valid` is 1 and `drv_idx` is the number of the highest set bit. When no `drv_sel` bit is set, `drv_valid` is 0 and `drv_idx` is 0.
- R5: With `offset` inside the bank and `offset[7:0] == 0`, `rd_data` is the bitwise inverse of the status byte. The status byte is built as follows:
  - bit 0 = `drv_absent[3]`;
  - bit 1 = `drv_absent[0]`;
  - bit 2 = `drv_absent[1]`;
  - bit 3 = `drv_absent[2]`;
  - bit 4 = `sw_step`;
  - bit 5 = `sw_clock`;
  - bits 7:6 = `sw_count`.
- R6: For any other `offset`, `rd_data` is 0. This covers an offset outside the bank and any nonzero `offset[7:0]`.
- R7: While `rst_n` is low, every control output is 0, and so are `drv_idx` and `drv_valid`.
- R8: `motor_trig` is the registered value of control bit 1 and holds its level until bit 1 is written again.
- R9: In a cycle with no accepted write, no control output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one bit |
| offset | input | ADDR_W | Byte offset on the bit bus |
| wr_bit | input | 1 | Data bit being written |
| rd_data | output | 8 | Read data (inverted status byte or 0) |
| drv_absent | input | 4 | Drive-absent flags, [0] = drive 1 |
| sw_step | input | 1 | Configuration switch 1 |
| sw_clock | input | 1 | Configuration switch 2 |
| sw_count | input | 2 | Drive-count switch pair |
| card_en | output | 1 | Card enable |
| motor_trig | output | 1 | Motor trigger level |
| wait_en | output | 1 | Wait-state enable |
| head_load | output | 1 | Head load |
| drv_sel | output | 4 | Raw drive select bits |
| side | output | 1 | Side select |
| dens | output | 1 | Density flag |
| rom_page | output | 2 | ROM page |
| ram_page | output | 1 | RAM page |
| rtc_en | output | 1 | Clock-chip enable |
| drv_idx | output | 2 | Selected drive index |
| drv_valid | output | 1 | A drive is selected |

## Verification
The assertions assume that `offset`, `wr_en` and `wr_bit` are stable around the rising edge and carry known values once reset is released. They also assume that the status inputs change only between reads. The stimulus meets this by driving every input on the falling edge, holding a write strobe for exactly one cycle, and setting the switch inputs before the read offset is applied. It does use writes whose offsets have bit 0 set, offsets outside the bank, and the two unused bit numbers, because these are legal bus traffic that the properties must tolerate.

// File: rtl/ctl_bit_bank.sv
module ctl_bit_bank #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] offset,
  input  logic              wr_bit,
  output logic [7:0]        rd_data,
  input  logic [3:0]        drv_absent,
  input  logic              sw_step,
  input  logic              sw_clock,
  input  logic [1:0]        sw_count,
  output logic              card_en,
  output logic              motor_trig,
  output logic              wait_en,
  output logic              head_load,
  output logic [3:0]        drv_sel,
  output logic              side,
  output logic              dens,
  output logic [1:0]        rom_page,
  output logic              ram_page,
  output logic              rtc_en,
  output logic [1:0]        drv_idx,
  output logic              drv_valid
);
  localparam logic [ADDR_W-1:0] WIN_MASK = {{(ADDR_W-8){1'b1}}, 8'h00};

  logic       in_bank;
  logic [3:0] bit_no;
  logic [7:0] status;

  assign in_bank = (offset & WIN_MASK) == BASE;
  assign bit_no  = offset[4:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      card_en    <= 1'b0;
      motor_trig <= 1'b0;
      wait_en    <= 1'b0;
      head_load  <= 1'b0;
      drv_sel    <= '0;
      side       <= 1'b0;
      dens       <= 1'b0;
      rom_page   <= '0;
      ram_page   <= 1'b0;
      rtc_en     <= 1'b0;
    end else if (wr_en && in_bank) begin
      case (bit_no)
        4'd0:  card_en     <= wr_bit;
        4'd1:  motor_trig  <= wr_bit;
        4'd2:  wait_en     <= wr_bit;
        4'd3:  head_load   <= wr_bit;
        4'd4:  drv_sel[0]  <= wr_bit;
        4'd5:  drv_sel[1]  <= wr_bit;
        4'd6:  drv_sel[2]  <= wr_bit;
        4'd7:  side        <= wr_bit;
        4'd8:  drv_sel[3]  <= wr_bit;
        4'd10: dens        <= wr_bit;
        4'd11: rom_page[0] <= wr_bit;
        4'd13: ram_page    <= wr_bit;
        4'd14: rtc_en      <= wr_bit;
        4'd15: rom_page[1] <= wr_bit;
        default: ;
      endcase
    end
  end

  always_comb begin
    drv_idx   = '0;
    drv_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (drv_sel[i]) begin
        drv_idx   = 2'(i);
        drv_valid = 1'b1;
      end
    end
  end

  assign status  = {sw_count, sw_clock, sw_step,
                    drv_absent[2], drv_absent[1], drv_absent[0], drv_absent[3]};
  assign rd_data = (in_bank && offset[7:0] == 8'h00) ? ~status : 8'h00;
endmodule

// File: rtl/ctl_bit_bank_chk.sv
module ctl_bit_bank_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] offset,
  input logic              wr_bit,
  input logic [7:0]        rd_data,
  input logic              card_en,
  input logic              motor_trig,
  input logic              wait_en,
  input logic              head_load,
  input logic [3:0]        drv_sel,
  input logic              side,
  input logic              dens,
  input logic [1:0]        rom_page,
  input logic              ram_page,
  input logic              rtc_en,
  input logic [1:0]        drv_idx,
  input logic              drv_valid
);
  logic [13:0] st;
  logic        hit;
  assign st  = {card_en, motor_trig, wait_en, head_load, drv_sel,
                side, dens, rom_page, ram_page, rtc_en};
  assign hit = wr_en && (offset[ADDR_W-1:8] == BASE[ADDR_W-1:8]);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st));
  p_outside_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(st));
  p_unused_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (offset[4:1] == 4'd9 || offset[4:1] == 4'd12)) |=> $stable(st));
  p_card_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && offset[4:1] == 4'd0) |=> card_en == $past(wr_bit));
  p_motor_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && offset[4:1] == 4'd1) |=> motor_trig == $past(wr_bit));
  p_highest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_valid |-> ((drv_sel >> drv_idx) == 4'b0001));
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_valid |-> (drv_sel == 4'b0000));
  p_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (offset[7:0] != 8'h00) |-> (rd_data == 8'h00));
endmodule

bind ctl_bit_bank ctl_bit_bank_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (.*);

// File: tb/test_ctl_bit_bank.sv
module test_ctl_bit_bank;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_bit = 0;
  logic [15:0] offset = 16'h0000;
  logic [7:0] rd_data;
  logic [3:0] drv_absent = 4'h0;
  logic sw_step = 0, sw_clock = 0;
  logic [1:0] sw_count = 0;
  logic card_en, motor_trig, wait_en, head_load, side, dens, ram_page, rtc_en, drv_valid;
  logic [3:0] drv_sel;
  logic [1:0] rom_page, drv_idx;
  int n_run = 0, n_fail = 0;

  ctl_bit_bank i_ctl_bit_bank (.*);

  always #10 clk = ~clk;

  logic [13:0] st;
  assign st = {card_en, motor_trig, wait_en, head_load, drv_sel,
               side, dens, rom_page, ram_page, rtc_en};

  // {offset, bit, expected state, expected {valid, idx}}
  localparam logic [33:0] VEC [16] = '{
    {16'h1100, 1'b1, 14'h2000, 3'b000},  // R2 card
    {16'h1102, 1'b1, 14'h3000, 3'b000},  // R2/R8 motor
    {16'h1104, 1'b1, 14'h3800, 3'b000},  // R2 wait
    {16'h110A, 1'b1, 14'h3880, 3'b101},  // R2 drive 2
    {16'h1110, 1'b1, 14'h3A80, 3'b111},  // R2/R4 drive 4 wins
    {16'h111E, 1'b1, 14'h3A88, 3'b111},  // R2 rom page 1
    {16'h111A, 1'b1, 14'h3A8A, 3'b111},  // R2 ram page
    {16'h111C, 1'b1, 14'h3A8B, 3'b111},  // R2 rtc
    {16'h1112, 1'b1, 14'h3A8B, 3'b111},  // R3 bit 9
    {16'h1103, 1'b0, 14'h2A8B, 3'b111},  // R1/R8 odd offset clears motor
    {16'h1200, 1'b0, 14'h2A8B, 3'b111},  // R1 outside bank
    {16'h1118, 1'b1, 14'h2A8B, 3'b111},  // R3 bit 12
    {16'h110E, 1'b1, 14'h2AAB, 3'b111},  // R2 side
    {16'h1114, 1'b1, 14'h2ABB, 3'b111},  // R2 density
    {16'h1116, 1'b1, 14'h2ABF, 3'b111},  // R2 rom page 0
    {16'h1106, 1'b1, 14'h2EBF, 3'b111}   // R2 head load
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] off, logic b);
    @(negedge clk);
    offset = off; wr_bit = b; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset state", {18'h0, st}, 32'h0);
    chk("R7 reset drive", {29'h0, drv_valid, drv_idx}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) begin
      wr(VEC[i][33:18], VEC[i][17]);
      chk("R1/R2/R3 state", {18'h0, st}, {18'h0, VEC[i][16:3]});
      chk("R4 drive", {29'h0, drv_valid, drv_idx}, {29'h0, VEC[i][2:0]});
    end

    // R9: a cycle with no write leaves the state alone
    @(negedge clk); offset = 16'h1100; wr_bit = 0;
    @(negedge clk);
    chk("R9 idle hold", {18'h0, st}, 32'h2EBF);

    // R4 priority walk
    wr(16'h1110, 0);
    chk("R4 only drive 2", {29'h0, drv_valid, drv_idx}, 32'h5);
    wr(16'h1108, 1);
    chk("R4 drives 1,2", {29'h0, drv_valid, drv_idx}, 32'h5);
    wr(16'h110C, 1);
    chk("R4 drives 1,2,3", {29'h0, drv_valid, drv_idx}, 32'h6);
    wr(16'h1108, 0); wr(16'h110A, 0); wr(16'h110C, 0);
    chk("R4 none", {29'h0, drv_valid, drv_idx}, 32'h0);
    wr(16'h1108, 1);
    chk("R4 drive 1", {29'h0, drv_valid, drv_idx}, 32'h4);

    // R5/R6 reads
    @(negedge clk);
    drv_absent = 4'b1000; sw_step = 1; sw_clock = 0; sw_count = 2'b01;
    offset = 16'h1100;
    #1 chk("R5 status a", {24'h0, rd_data}, 32'hAE);
    drv_absent = 4'b0011; sw_step = 0; sw_clock = 1; sw_count = 2'b11;
    #1 chk("R5 status b", {24'h0, rd_data}, 32'h19);
    offset = 16'h1102;
    #1 chk("R6 other byte", {24'h0, rd_data}, 32'h0);
    offset = 16'h1200;
    #1 chk("R6 outside", {24'h0, rd_data}, 32'h0);

    // R7: reset clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R7 reset clears", {18'h0, st}, 32'h0);
    chk("R7 reset drive", {29'h0, drv_valid, drv_idx}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule